// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block sends one low-speed USB packet onto the differential pair, one packet per start pulse. The block generates the synchronization byte itself. It then fetches the remaining bytes of the packet from an external byte store through an index port. Bits leave least significant first, at a fixed ten clock cycles per bit. Each bit is NRZI-coded, and a stuffed zero is inserted after every run of six ones. After the last bit the block drives an end-of-packet: single-ended zero for two bit times, then one cycle of idle J, and then it lets go of the bus.

The caller pulses `start` together with the total packet length in bytes, counting the synchronization byte. A length of two makes a handshake reply: sync plus one PID byte. Any longer packet counts as a data packet. When a data packet's end-of-packet begins, a pending device address is copied into the active address register. A single-cycle strobe goes out at the same moment, so that the surrounding logic can drop any receive-start flag raised by the block's own traffic.

Top module: `ls_usb_tx`

## Requirements
- R1: After reset `oe` is 0, the line shows idle J (`dp`=0, `dm`=1), `busy`, `done` and `rxFlagClear` are 0 and `curAddr` is 0.
- R2: A `start` seen while idle produces exactly one cycle with J levels and `oe` low. In the following cycle `oe` rises and the first bit level is already on the line, two cycles after the start edge.
- R3: The first byte on the wire is 0x80, produced internally. After it come `byteCount`-1 bytes, read from `byteIn` while `byteIdx` counts 0, 1, 2 and so on. Every byte is sent least significant bit first.
- R4: NRZI coding starts from J. A 0 bit toggles the line (J = `dp` 0/`dm` 1, K = `dp` 1/`dm` 0) and a 1 bit keeps it.
- R5: After six consecutive 1 bits a toggle (stuffed 0) is inserted. The run carries across byte boundaries, and a run completed by the final bit still receives its stuffed bit.
- R6: Every bit, stuffed or not, holds its level for exactly 10 clock cycles.
- R7: A `byteCount` below 2 is treated as 2, and one above 12 is treated as 12.
- R8: Right after the last bit, `dp` and `dm` are both 0 for 20 cycles with `oe` high. Then comes one cycle of J with `oe` high, and then `oe` falls.
- R9: `done` is high for exactly the one cycle in which `oe` first falls after a packet. `busy` is high from the cycle after the start edge through the final J cycle.
- R10: In the first single-ended-zero cycle, `curAddr` takes the value of `pendAddr`, but only for a packet longer than 2 bytes. At any other time it holds.
- R11: `rxFlagClear` is high for exactly the first single-ended-zero cycle of each packet.
- R12: A `start` pulse while `busy` is high is ignored, whatever `byteCount` shows at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 cycles per bit |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to send a packet |
| byteCount | input | 4 | Packet length in bytes including sync, sampled with `start` |
| byteIn | input | 8 | Byte at position `byteIdx` of the payload store |
| pendAddr | input | 7 | Address to become active after a data packet |
| byteIdx | output | 4 | Index of the payload byte to present on `byteIn` |
| dp | output | 1 | D+ level |
| dm | output | 1 | D- level |
| oe | output | 1 | Output enable for the pair |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse when the bus is released |
| rxFlagClear | output | 1 | One-cycle pulse at the start of end-of-packet |
| curAddr | output | 7 | Active device address |

## Verification
Two things can land in the same cycle: the `done` pulse that ends one packet and a `start` that opens the next. The bench provokes this by raising `start` in the very cycle `done` is high. The new packet must then show its J/oe-low setup cycle immediately, with `done` already back to 0, and its bit stream must match the expected sequence exactly in time. A second overlap is a `start`, with a different length, arriving in the middle of a packet. The ongoing packet must keep its computed bit count and end-of-packet timing.

// File: rtl/ls_usb_tx_pkg.sv
package ls_usb_tx_pkg;

  typedef enum logic [1:0] {
    DRV_IDLE,
    DRV_DATA,
    DRV_SE0,
    DRV_J
  } drive_e;

  typedef struct packed {
    logic   init;
    logic   emit;
    logic   eop;
    drive_e drive;
  } tx_strobe_t;

endpackage

// File: rtl/ls_usb_tx_ctrl.sv
module ls_usb_tx_ctrl
  import ls_usb_tx_pkg::*;
#(
  parameter int BIT_CLKS = 10,
  parameter int SE0_BITS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       moreBits,
  output tx_strobe_t st,
  output logic       busy,
  output logic       done,
  output logic       rxFlagClear
);

  localparam int SE0_CLKS = SE0_BITS * BIT_CLKS;
  localparam int TMR_W    = $clog2(SE0_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_BITS, S_SE0, S_JDRV} state_e;

  state_e           state;
  logic [TMR_W-1:0] timer;
  logic             bitEnd;

  assign bitEnd = (state == S_BITS) && (timer == TMR_W'(BIT_CLKS - 1));

  always_comb begin
    st.init  = (state == S_IDLE) && start;
    st.emit  = (state == S_PREP) || (bitEnd && moreBits);
    st.eop   = bitEnd && !moreBits;
    case (state)
      S_BITS:  st.drive = DRV_DATA;
      S_SE0:   st.drive = DRV_SE0;
      S_JDRV:  st.drive = DRV_J;
      default: st.drive = DRV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      timer       <= '0;
      done        <= 1'b0;
      rxFlagClear <= 1'b0;
    end else begin
      done        <= (state == S_JDRV);
      rxFlagClear <= st.eop;
      case (state)
        S_IDLE: if (start) state <= S_PREP;
        S_PREP: begin
          state <= S_BITS;
          timer <= '0;
        end
        S_BITS: begin
          if (bitEnd) begin
            timer <= '0;
            if (!moreBits) state <= S_SE0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_SE0: begin
          if (timer == TMR_W'(SE0_CLKS - 1)) begin
            state <= S_JDRV;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // R9: done never lasts two cycles
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: the end-of-packet strobe is a single pulse
  assert_eop_strobe_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxFlagClear |=> !rxFlagClear);

  // R6: bit/SE0 timer stays inside its window
  assert_timer_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    timer < TMR_W'(SE0_CLKS));

  // R12: while busy, a start does not re-arm the packet
  assert_busy_ignores_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && state != S_JDRV) |=> busy);

endmodule

// File: rtl/ls_usb_tx_dp.sv
module ls_usb_tx_dp
  import ls_usb_tx_pkg::*;
#(
  parameter int MAX_BYTES = 12,
  parameter int STUFF_RUN = 6,
  parameter int ADDR_W    = 7,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tx_strobe_t        st,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        byteIn,
  input  logic [ADDR_W-1:0] pendAddr,
  output logic [CNT_W-1:0]  byteIdx,
  output logic [ADDR_W-1:0] curAddr,
  output logic              moreBits,
  output logic              dp,
  output logic              dm,
  output logic              oe
);

  localparam int         RUN_W     = $clog2(STUFF_RUN + 1);
  localparam logic [7:0] SYNC_BYTE = 8'h80;

  logic [7:0]       shiftReg;
  logic [3:0]       bitsLeft;
  logic [CNT_W-1:0] bytesLeft;
  logic [CNT_W-1:0] effCount;
  logic [RUN_W-1:0] onesRun;
  logic             lineK;
  logic             dataPkt;
  logic             stuffDue;

  always_comb begin
    if (byteCount < CNT_W'(2))              effCount = CNT_W'(2);
    else if (byteCount > CNT_W'(MAX_BYTES)) effCount = CNT_W'(MAX_BYTES);
    else                                    effCount = byteCount;
  end

  assign stuffDue = (onesRun == RUN_W'(STUFF_RUN));
  assign moreBits = (bitsLeft != '0) || (bytesLeft != '0) || stuffDue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitsLeft  <= '0;
      bytesLeft <= '0;
      byteIdx   <= '0;
      onesRun   <= '0;
      lineK     <= 1'b0;
      dataPkt   <= 1'b0;
      curAddr   <= '0;
    end else begin
      if (st.init) begin
        shiftReg  <= SYNC_BYTE;
        bitsLeft  <= 4'd8;
        bytesLeft <= effCount - 1'b1;
        byteIdx   <= '0;
        onesRun   <= '0;
        lineK     <= 1'b0;
        dataPkt   <= (effCount > CNT_W'(2));
      end else if (st.emit) begin
        if (stuffDue) begin
          lineK   <= ~lineK;
          onesRun <= '0;
        end else begin
          if (shiftReg[0]) begin
            onesRun <= onesRun + 1'b1;
          end else begin
            onesRun <= '0;
            lineK   <= ~lineK;
          end
          if (bitsLeft == 4'd1 && bytesLeft != '0) begin
            shiftReg  <= byteIn;
            bitsLeft  <= 4'd8;
            bytesLeft <= bytesLeft - 1'b1;
            byteIdx   <= byteIdx + 1'b1;
          end else begin
            shiftReg <= {1'b0, shiftReg[7:1]};
            bitsLeft <= bitsLeft - 1'b1;
          end
        end
      end
      if (st.eop && dataPkt) curAddr <= pendAddr;
    end
  end

  always_comb begin
    case (st.drive)
      DRV_DATA: begin dp = lineK; dm = ~lineK; oe = 1'b1; end
      DRV_SE0:  begin dp = 1'b0;  dm = 1'b0;   oe = 1'b1; end
      DRV_J:    begin dp = 1'b0;  dm = 1'b1;   oe = 1'b1; end
      default:  begin dp = 1'b0;  dm = 1'b1;   oe = 1'b0; end
    endcase
  end

  // R2: the bus is only taken while J was already presented
  assert_take_bus_from_j_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oe) |-> ($past(dp) == 1'b0 && $past(dm) == 1'b1));

  // R8: single-ended zero only appears while driving
  assert_se0_driven_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!dp && !dm) |-> oe);

  // R5: the ones run never passes the stuffing limit
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    onesRun <= RUN_W'(STUFF_RUN));

  // R10: the active address only moves on an end-of-packet strobe
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !st.eop |=> $stable(curAddr));

  // R3: remaining bytes only shrink between starts
  assert_bytes_monotone_R3: assert property (@(posedge clk) disable iff (!rstN)
    !st.init |=> bytesLeft <= $past(bytesLeft));

endmodule

// File: rtl/ls_usb_tx.sv
module ls_usb_tx
  import ls_usb_tx_pkg::*;
#(
  parameter int BIT_CLKS  = 10,
  parameter int SE0_BITS  = 2,
  parameter int MAX_BYTES = 12,
  parameter int STUFF_RUN = 6,
  parameter int ADDR_W    = 7,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        byteIn,
  input  logic [ADDR_W-1:0] pendAddr,
  output logic [CNT_W-1:0]  byteIdx,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic              busy,
  output logic              done,
  output logic              rxFlagClear,
  output logic [ADDR_W-1:0] curAddr
);

  tx_strobe_t st;
  logic       moreBits;

  ls_usb_tx_ctrl #(
    .BIT_CLKS(BIT_CLKS),
    .SE0_BITS(SE0_BITS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .moreBits   (moreBits),
    .st         (st),
    .busy       (busy),
    .done       (done),
    .rxFlagClear(rxFlagClear)
  );

  ls_usb_tx_dp #(
    .MAX_BYTES(MAX_BYTES),
    .STUFF_RUN(STUFF_RUN),
    .ADDR_W   (ADDR_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .byteCount(byteCount),
    .byteIn   (byteIn),
    .pendAddr (pendAddr),
    .byteIdx  (byteIdx),
    .curAddr  (curAddr),
    .moreBits (moreBits),
    .dp       (dp),
    .dm       (dm),
    .oe       (oe)
  );

endmodule

// File: tb/ls_usb_tx_tb_top.sv
module ls_usb_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BITC       = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] byteCount = 4'd2;
  logic [7:0] byteIn;
  logic [6:0] pendAddr = '0;
  logic [3:0] byteIdx;
  logic       dp, dm, oe, busy, done, rxFlagClear;
  logic [6:0] curAddr;

  logic [7:0] mem [0:15];
  logic       expLine [0:255];
  int         checks = 0;
  int         errors = 0;
  logic [6:0] modelAddr = '0;

  assign byteIn = mem[byteIdx];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ls_usb_tx dut_i (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .byteIn(byteIn), .pendAddr(pendAddr), .byteIdx(byteIdx),
    .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done),
    .rxFlagClear(rxFlagClear), .curAddr(curAddr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] patByte(input int p, input int i, input int cnt);
    case (p)
      0: return 8'hFF;
      1: return 8'h00;
      2: return 8'((i * 37 + cnt) & 255);
      3: return (i == cnt - 2) ? 8'hFC : 8'h3F;
      default: return 8'(((i * 113) ^ 8'h5A) & 255);
    endcase
  endfunction

  // Builds expected per-bit line levels (1 = K); returns the bit count.
  function automatic int buildLine(input int eff);
    int run = 0;
    int n = 0;
    logic ln = 1'b0;
    for (int b = 0; b < eff; b++) begin
      logic [7:0] v;
      v = (b == 0) ? 8'h80 : mem[b - 1];
      for (int i = 0; i < 8; i++) begin
        if (v[i]) run++;
        else begin ln = ~ln; run = 0; end
        expLine[n] = ln; n++;
        if (run == 6) begin ln = ~ln; run = 0; expLine[n] = ln; n++; end
      end
    end
    return n;
  endfunction

  task automatic sendPkt(input int cnt, input int p, input bit b2b, input int midBit);
    int eff, n;
    logic [6:0] oldAddr, newAddr;
    eff = (cnt < 2) ? 2 : ((cnt > 12) ? 12 : cnt);
    for (int i = 0; i < 16; i++) mem[i] = patByte(p, i, eff);
    n = buildLine(eff);
    oldAddr = modelAddr;
    if (!b2b) @(negedge clk);
    pendAddr  = 7'((cnt * 11 + p * 5 + 3) & 127);
    newAddr   = (eff > 2) ? pendAddr : oldAddr;
    byteCount = 4'(cnt);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // setup cycle
    chk(oe == 1'b0 && dp == 1'b0 && dm == 1'b1, "R2 setup J with oe low", {oe, dp, dm}, 3'b001);
    chk(busy == 1'b1 && done == 1'b0, "R9 busy in setup, done low", {busy, done}, 2'b10);
    for (int c = 0; c <= BITC * n + 21; c++) begin
      @(negedge clk);
      if (c < BITC * n) begin
        if (c == 0) chk(oe == 1'b1, "R2 oe up with first bit", oe, 1);
        if (c % BITC == 0 || c % BITC == 5 || c % BITC == BITC - 1) begin
          chk(dp == expLine[c / BITC] && dm == !expLine[c / BITC] && oe,
              (c % BITC == 5) ? "R4/R5 bit level" : "R6 bit edge hold",
              {dp, dm}, {expLine[c / BITC], !expLine[c / BITC]});
        end
        if (c == BITC * n - 1) begin
          chk(curAddr == oldAddr, "R10 address unchanged before eop", curAddr, oldAddr);
          chk(rxFlagClear == 1'b0, "R11 no strobe before eop", rxFlagClear, 0);
        end
      end else if (c == BITC * n) begin
        chk(!dp && !dm && oe, "R8 SE0 begins", {dp, dm, oe}, 3'b001);
        chk(rxFlagClear == 1'b1, "R11 strobe at first SE0", rxFlagClear, 1);
        chk(curAddr == newAddr, "R10 address after eop", curAddr, newAddr);
      end else if (c == BITC * n + 1) begin
        chk(rxFlagClear == 1'b0, "R11 strobe single", rxFlagClear, 0);
      end else if (c == BITC * n + 19) begin
        chk(!dp && !dm && oe, "R8 SE0 last cycle", {dp, dm, oe}, 3'b001);
      end else if (c == BITC * n + 20) begin
        chk(!dp && dm && oe && busy && !done, "R8 J drive cycle", {dp, dm, oe, busy, done}, 5'b01110);
      end else if (c == BITC * n + 21) begin
        chk(!oe && !busy && done, "R9 release with done", {oe, busy, done}, 3'b001);
        chk(!dp && dm, "R1 idle J after release", {dp, dm}, 2'b01);
      end
      if (midBit >= 0 && c == BITC * midBit + 2) begin
        start = 1'b1; byteCount = 4'd3;
      end
      if (midBit >= 0 && c == BITC * midBit + 3) begin
        start = 1'b0; byteCount = 4'(cnt);
        chk(busy == 1'b1, "R12 start while busy ignored", busy, 1);
      end
    end
    modelAddr = newAddr;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(oe == 1'b0 && dp == 1'b0 && dm == 1'b1, "R1 reset line", {oe, dp, dm}, 3'b001);
    chk(!busy && !done && !rxFlagClear, "R1 reset flags", {busy, done, rxFlagClear}, 0);
    chk(curAddr == 7'd0, "R1 reset address", curAddr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(oe == 1'b0 && !busy, "R1 idle after reset", {oe, busy}, 0);

    // R3 R4 R5 R6: sweep lengths and data patterns
    for (int cnt = 2; cnt <= 12; cnt++)
      for (int p = 0; p < 5; p++)
        sendPkt(cnt, p, 1'b0, -1);

    // R7: lengths outside the legal range
    sendPkt(0, 2, 1'b0, -1);
    sendPkt(1, 0, 1'b0, -1);
    sendPkt(13, 4, 1'b0, -1);
    sendPkt(15, 3, 1'b0, -1);

    // R12: start pulses in the middle of packets
    sendPkt(5, 2, 1'b0, 3);
    sendPkt(2, 0, 1'b0, 10);

    // R9: back-to-back start in the done cycle, data then handshake
    sendPkt(4, 3, 1'b0, -1);
    sendPkt(2, 1, 1'b1, -1);
    sendPkt(7, 0, 1'b1, -1);

    repeat (3) @(negedge clk);
    chk(!oe && !done && !busy, "R9 quiet after last packet", {oe, done, busy}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule